// File: doc/BRIEF.md
# Serial-Loaded Configuration Register File

This block holds four 5-bit configuration registers that a CPU fills through a one-bit serial path. Every CPU write delivers a single data bit in bit 0 of the data bus. Bit 7 of the same byte acts as a clear flag. Once five bits have been accepted, the assembled value is written into one of the four registers. The register is picked by the two address bits presented with the fifth write. Any address bits sent with the earlier writes are disregarded.

A write filter protects the load against CPU instructions that write twice on adjacent cycles. Each write, whether accepted or not, reloads a small filter counter to 2. The counter counts down once per CPU-cycle tick. A data write that arrives while the counter is nonzero is discarded. A clear write always takes effect. A clear write also forces two mode bits of register 0 high. Decoding the registers into bank selections is left to the logic that reads them.

Top module: `serial_cfg_loader`

## Requirements
- R1: A write whose data bit 7 is 1 empties the accumulator and the accepted-bit count, so the next five accepted data writes form a fresh value.
- R2: A write whose data bit 7 is 1 sets bits 3 and 2 of register 0 to 1 and leaves bits 4, 1 and 0 of register 0 as they were. Registers 1 to 3 are unchanged.
- R3: A data write contributes only data bit 0, and data bits 6 to 1 have no effect. Accepted bits are placed LSB first: the first accepted bit ends up in register bit 0 and the fifth in register bit 4.
- R4: The fifth accepted data write commits the value to the register numbered by `wr_addr` (the CPU address bits 14:13) of that write. The count then restarts from zero.
- R5: Each write reloads the filter to 2, and each `cpu_tick` cycle without a write lowers it by 1. A data write seen while the filter is nonzero is ignored and changes no register and no load progress. A data write is therefore accepted only after at least two ticks since the previous write.
- R6: A clear write is acted on even while the filter is nonzero, and it reloads the filter to 2 like any other write.
- R7: After reset, register 0 reads 0x0C, registers 1 to 3 read 0, and the filter, the accumulator and the count are all zero, so the first write is accepted.
- R8: When a write and a tick fall in the same cycle, the reload wins and the filter becomes 2. The filter holds at zero and never goes below it.
- R9: A register changes only on the clock edge that samples a committing write or a clear write. It is visible on `cfg_o` right after that edge, and every other register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle CPU write strobe for this register file |
| wr_addr | input | 2 | CPU address bits 14:13; they select the target register on the committing write |
| wr_data | input | 8 | CPU data bus; bit 7 is the clear flag and bit 0 is the serial bit |
| cpu_tick | input | 1 | High for one clock per CPU cycle; it ages the write filter |
| cfg_o | output | 20 | Register contents, with register n at bits 5n+4 to 5n |

## Verification
Register results are due on the same clock edge that samples the committing or clear write. No pipeline stage lies between the strobe and `cfg_o`. The filter state shows up one edge later, as acceptance or rejection of the next write. The bench drives every input on the falling edge and holds a write for exactly one rising edge. It reads `cfg_o` at the next falling edge, so each comparison lands half a period after the edge that is meant to change the register. Filter cases are arranged so that the number of tick edges between two writes is known exactly. A dropped write is shown by a register that stays unchanged after four accepted bits, and by the value built from the bits that follow.

// File: rtl/scl_pkg.sv
package scl_pkg;

    // Classification of one CPU write after the filter has been consulted
    typedef enum logic [1:0] {
        WR_IDLE    = 2'd0,
        WR_CLEAR   = 2'd1,
        WR_SHIFT   = 2'd2,
        WR_BLOCKED = 2'd3
    } wr_kind_e;

endpackage

// File: rtl/scl_write_gate.sv
module scl_write_gate
    import scl_pkg::*;
#(
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned RESET_BIT     = 7,
    parameter int unsigned FILTER_RELOAD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              cpu_tick,
    input  logic [DATA_W-1:0] wr_data,
    output wr_kind_e          kind_o
);

    localparam int unsigned FILT_W = (FILTER_RELOAD < 2) ? 1 : $clog2(FILTER_RELOAD + 1);
    localparam logic [FILT_W-1:0] RELOAD_V = FILT_W'(FILTER_RELOAD);
    localparam logic [FILT_W-1:0] ONE_V    = FILT_W'(1);

    typedef struct packed {
        logic [FILT_W-1:0] filt;
    } gate_state_t;

    gate_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.filt = RELOAD_V;
        end else if (cpu_tick && (st_q.filt != '0)) begin
            st_d.filt = st_q.filt - ONE_V;
        end
    end

    always_comb begin
        if (!wr_en) begin
            kind_o = WR_IDLE;
        end else if (wr_data[RESET_BIT]) begin
            kind_o = WR_CLEAR;
        end else if (st_q.filt != '0) begin
            kind_o = WR_BLOCKED;
        end else begin
            kind_o = WR_SHIFT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Any write, including a clear or a blocked one, re-arms the filter
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.filt == RELOAD_V);

    // Reload beats a coincident tick
    p_tick_and_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cpu_tick) |=> st_q.filt == RELOAD_V);

    p_decay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && cpu_tick && st_q.filt != '0) |=> st_q.filt == $past(st_q.filt) - ONE_V);

    p_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && st_q.filt == '0) |=> st_q.filt == '0);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !cpu_tick) |=> $stable(st_q.filt));

endmodule

// File: rtl/scl_shift_acc.sv
module scl_shift_acc
    import scl_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_kind_e         kind_i,
    input  logic             bit_i,
    output logic             commit_o,
    output logic [REG_W-1:0] value_o
);

    localparam int unsigned CNT_W = (REG_W < 3) ? 1 : $clog2(REG_W);
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(REG_W - 1);
    localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [REG_W-2:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        commit_o = 1'b0;
        value_o  = {bit_i, st_q.acc};
        case (kind_i)
            WR_CLEAR: begin
                st_d = '0;
            end
            WR_SHIFT: begin
                if (st_q.cnt == LAST_V) begin
                    commit_o = 1'b1;
                    st_d     = '0;
                end else begin
                    st_d.acc[st_q.cnt] = bit_i;
                    st_d.cnt           = st_q.cnt + ONE_V;
                end
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        kind_i == WR_CLEAR |=> (st_q.cnt == '0 && st_q.acc == '0));

    p_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        kind_i == WR_BLOCKED |=> $stable(st_q));

    p_lsb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == WR_SHIFT && st_q.cnt != LAST_V) |=> st_q.acc[$past(st_q.cnt)] == $past(bit_i));

    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> st_q.cnt == '0);

    p_count_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST_V);

endmodule

// File: rtl/scl_reg_bank.sv
module scl_reg_bank #(
    parameter int unsigned REG_W      = 5,
    parameter int unsigned NUM_REGS   = 4,
    parameter logic [REG_W-1:0] CTRL_INIT  = 5'h0C,
    parameter logic [REG_W-1:0] CTRL_FORCE = 5'h0C,
    localparam int unsigned SEL_W = (NUM_REGS < 3) ? 1 : $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit_i,
    input  logic                      clear_i,
    input  logic [SEL_W-1:0]          sel_i,
    input  logic [REG_W-1:0]          value_i,
    output logic [NUM_REGS*REG_W-1:0] regs_o
);

    typedef struct packed {
        logic [NUM_REGS-1:0][REG_W-1:0] r;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [NUM_REGS-1:0][REG_W-1:0] nxt;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic hit;
        assign hit = commit_i && (sel_i == SEL_W'(i));
        if (i == 0) begin : g_ctrl
            assign nxt[i] = hit     ? value_i :
                            clear_i ? (st_q.r[i] | CTRL_FORCE) :
                                      st_q.r[i];
        end else begin : g_plain
            assign nxt[i] = hit ? value_i : st_q.r[i];
        end
    end

    always_comb begin
        st_d   = st_q;
        st_d.r = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.r[0] <= CTRL_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o = st_q.r;

    p_force_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.r[0] & CTRL_FORCE) == CTRL_FORCE);

    p_keep_other_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.r[0] & ~CTRL_FORCE) == ($past(st_q.r[0]) & ~CTRL_FORCE));

    p_commit_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> st_q.r[$past(sel_i)] == $past(value_i));

    p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_i && !clear_i) |=> $stable(st_q.r));

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import scl_pkg::*;
#(
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned REG_W         = 5,
    parameter int unsigned NUM_REGS      = 4,
    parameter int unsigned RESET_BIT     = 7,
    parameter int unsigned FILTER_RELOAD = 2,
    parameter logic [REG_W-1:0] CTRL_INIT  = 5'h0C,
    parameter logic [REG_W-1:0] CTRL_FORCE = 5'h0C,
    localparam int unsigned SEL_W = (NUM_REGS < 3) ? 1 : $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      cpu_tick,
    output logic [NUM_REGS*REG_W-1:0] cfg_o
);

    wr_kind_e         kind;
    logic             commit;
    logic [REG_W-1:0] value;

    scl_write_gate #(
        .DATA_W        (DATA_W),
        .RESET_BIT     (RESET_BIT),
        .FILTER_RELOAD (FILTER_RELOAD)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .cpu_tick (cpu_tick),
        .wr_data  (wr_data),
        .kind_o   (kind)
    );

    scl_shift_acc #(
        .REG_W (REG_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind_i   (kind),
        .bit_i    (wr_data[0]),
        .commit_o (commit),
        .value_o  (value)
    );

    scl_reg_bank #(
        .REG_W      (REG_W),
        .NUM_REGS   (NUM_REGS),
        .CTRL_INIT  (CTRL_INIT),
        .CTRL_FORCE (CTRL_FORCE)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .clear_i  (kind == WR_CLEAR),
        .sel_i    (wr_addr),
        .value_i  (value),
        .regs_o   (cfg_o)
    );

endmodule

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // Each entry: {target register[1:0], value[4:0]}
    localparam logic [6:0] VEC [0:NVEC-1] = '{
        {2'd1, 5'h15}, {2'd2, 5'h0A}, {2'd3, 5'h1F}, {2'd0, 5'h01},
        {2'd1, 5'h10}, {2'd3, 5'h00}, {2'd2, 5'h13}, {2'd0, 5'h1E}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       cpu_tick = 1'b0;
    logic [19:0] cfg_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [4:0] exp_r [0:3];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_cfg_loader u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cpu_tick (cpu_tick),
        .cfg_o    (cfg_o)
    );

    task automatic check_val(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 4; i++) begin
            check_val(req, cfg_o[i*5 +: 5], exp_r[i]);
        end
    endtask

    // One write strobe, sampled at exactly one rising edge
    task automatic do_write(input logic [1:0] sel, input logic [7:0] d, input logic tk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = sel; wr_data = d; cpu_tick = tk;
        @(negedge clk);
        wr_en = 1'b0; cpu_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cpu_tick = 1'b1;
        end
        @(negedge clk);
        cpu_tick = 1'b0;
    endtask

    // Data write with junk in bits 6..1 (R3), then enough ticks to open the filter
    task automatic bit_wr(input logic [1:0] sel, input logic b);
        do_write(sel, {1'b0, 6'b101101, b}, 1'b0);
        ticks(2);
    endtask

    // Earlier writes use a different address: only the last one selects (R4)
    task automatic load(input logic [1:0] sel, input logic [4:0] v);
        for (int i = 0; i < 5; i++) begin
            bit_wr((i == 4) ? sel : ~sel, v[i]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_r[0] = 5'h0C; exp_r[1] = 5'h00; exp_r[2] = 5'h00; exp_r[3] = 5'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R7 power-on values");

        // Table walk: LSB-first assembly and address selection (R3, R4, R9)
        for (int v = 0; v < NVEC; v++) begin
            load(VEC[v][6:5], VEC[v][4:0]);
            exp_r[VEC[v][6:5]] = VEC[v][4:0];
            check_all("R3/R4/R9 table load");
        end

        // R2: clear write forces bits 3:2 of register 0, keeps the rest
        load(2'd0, 5'h13); exp_r[0] = 5'h13;
        check_all("R4 reg0 load");
        do_write(2'd2, 8'hA4, 1'b0); ticks(2);
        exp_r[0] = 5'h1F;
        check_all("R2 clear on 0x13");
        load(2'd0, 5'h01); exp_r[0] = 5'h01;
        do_write(2'd1, 8'h80, 1'b0); ticks(2);
        exp_r[0] = 5'h0D;
        check_all("R2 clear on 0x01");

        // R1: partial load discarded by clear
        bit_wr(2'd2, 1'b1); bit_wr(2'd2, 1'b1); bit_wr(2'd2, 1'b1);
        do_write(2'd2, 8'hFF, 1'b0); ticks(2);
        check_all("R1 no commit after clear");
        for (int i = 0; i < 4; i++) bit_wr(2'd2, 1'b0);
        check_all("R1 four fresh bits do not commit");
        bit_wr(2'd2, 1'b1);
        exp_r[2] = 5'h10;
        check_all("R1 fresh value after clear");

        // R5: writes too close together are dropped
        bit_wr(2'd3, 1'b1); bit_wr(2'd3, 1'b0); bit_wr(2'd3, 1'b0);
        do_write(2'd3, 8'h00, 1'b0);                 // 4th accepted, no ticks after
        do_write(2'd3, 8'h01, 1'b0);                 // filter 2 -> dropped
        check_all("R5 back-to-back write dropped");
        ticks(1);
        do_write(2'd3, 8'h00, 1'b0);                 // filter 1 -> dropped, reloads
        check_all("R5 write after one tick dropped");
        ticks(2);
        do_write(2'd3, 8'h01, 1'b0);                 // accepted 5th bit
        exp_r[3] = 5'h11;
        check_all("R5 value excludes dropped bits");
        ticks(2);

        // R6: clear honoured while filter busy, and it reloads the filter
        load(2'd0, 5'h00); exp_r[0] = 5'h00;
        check_all("R4 reg0 zeroed");
        do_write(2'd1, 8'h01, 1'b0);                 // accepted bit, filter 2
        do_write(2'd1, 8'h80, 1'b0);                 // clear, not blocked
        exp_r[0] = 5'h0C;
        check_all("R6 clear passes busy filter");
        do_write(2'd1, 8'h01, 1'b0);                 // dropped: clear reloaded filter
        ticks(2);
        for (int i = 0; i < 4; i++) bit_wr(2'd1, 1'b1);
        check_all("R6 write after clear was dropped");
        bit_wr(2'd1, 1'b0);
        exp_r[1] = 5'h0F;
        check_all("R6 load after clear");

        // R8: write and tick in the same cycle -> filter 2
        do_write(2'd2, 8'h01, 1'b1);                 // accepted bit 0 = 1
        ticks(1);
        do_write(2'd2, 8'h00, 1'b0);                 // filter 1 -> dropped
        ticks(5);                                    // filter floors at zero
        bit_wr(2'd2, 1'b0); bit_wr(2'd2, 1'b1); bit_wr(2'd2, 1'b1);
        check_all("R8 no early commit");
        bit_wr(2'd2, 1'b0);
        exp_r[2] = 5'h0D;
        check_all("R8 reload wins over coincident tick");

        // R7: reset in mid-load restores power-on state
        bit_wr(2'd3, 1'b1); bit_wr(2'd3, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        exp_r[0] = 5'h0C; exp_r[1] = 5'h00; exp_r[2] = 5'h00; exp_r[3] = 5'h00;
        check_all("R7 values after reset");
        do_write(2'd0, 8'h01, 1'b0);                 // first write accepted at once
        for (int i = 0; i < 4; i++) do_write(2'd0, 8'h00, 1'b0); // all dropped
        ticks(2);
        for (int i = 0; i < 4; i++) bit_wr(2'd0, 1'b0);
        exp_r[0] = 5'h01;
        check_all("R7 empty filter and count after reset");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule